// File: doc/BRIEF.md
# Scratch Register Doorbell Event Unit

This unit holds two configuration-space registers behind a simple register port. The first is a 16-bit software SMI register. Its upper byte is free scratch storage. Bits 7:1 form a flag field that carries the caller, the requested function and a return result. Bit 0 is an event bit that drives a system-management interrupt request.

The second register is a 32-bit display-event register made of four independent scratch bytes. A write to any of these bytes acts as a doorbell and raises an interrupt pulse. The pulse fires only when the enable input is set and the mask input is clear. An access that covers several bytes still yields only one pulse.

Software talks to the unit through an address, byte enables, write data and a write strobe. Read data is returned combinationally for the address presented. Full configuration decoding and the interrupt controller are handled outside this block.

Top module: `doorbell_regs`

## Requirements
- R1: After reset both registers read as zero, `smi_out` is 0 and `irq_pulse` is 0.
- R2: The SMI register is at address E0h and sits in byte lanes 0 and 1 (bits 15:0). Each lane is written only when its byte enable is set. Bits 31:16 read as zero.
- R3: `smi_out` equals bit 0 of the SMI register. It rises on a write of 1 to that bit and falls only when a write with `reg_be[0]` set stores 0 there. A write that touches only lane 1 leaves bits 7:0 and `smi_out` unchanged.
- R4: The event register is at address E4h and holds four bytes in lanes 0 to 3. Each byte is written only when its byte enable `reg_be[n]` is set.
- R5: When a write to E4h with at least one byte enable set is accepted while `irq_enable`=1 and `irq_mask`=0, `irq_pulse` is high for exactly the next clock cycle.
- R6: One access produces exactly one pulse, whether it covers 1, 2 or 4 bytes.
- R7: No pulse fires when `irq_enable`=0, when `irq_mask`=1, or when all byte enables are clear. The written bytes are still stored in these cases.
- R8: Any address other than exactly E0h or E4h reads as zero, and writes to it change no state.
- R9: Reads have no side effects: presenting an address without `reg_we` changes no register, `smi_out` or `irq_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W (8) | Byte address of the access |
| reg_be | input | 4 | Byte enables, one per data lane |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe; write accepted on the rising clock edge |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_enable | input | 1 | Doorbell interrupt enable |
| irq_mask | input | 1 | Doorbell interrupt mask (1 = masked) |
| smi_out | output | 1 | SMI request level |
| irq_pulse | output | 1 | One-cycle doorbell interrupt pulse |

## Verification
A wrong stored byte appears on `reg_rdata` in the cycle after the write, because the bench reads the addressed register back on every clock. A stuck or wrongly cleared event bit shows on `smi_out` in that same cycle. A broken doorbell qualifier or lane merge shows as an extra, missing or two-cycle `irq_pulse` one cycle after the access. A decode error shows at once as nonzero data at an unmapped address, or as a changed register after a stray write.

// File: rtl/doorbell_regs.sv
module doorbell_regs #(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [7:0]  SMI_ADDR = 8'hE0,
  parameter logic [7:0]  EVT_ADDR = 8'hE4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_we,
  output logic [31:0]       reg_rdata,
  input  logic              irq_enable,
  input  logic              irq_mask,
  output logic              smi_out,
  output logic              irq_pulse
);
  localparam int unsigned LANES = 4;

  logic [15:0] smi_q;
  logic [31:0] evt_q;
  logic        irq_q;

  wire hit_smi = (reg_addr == ADDR_W'(SMI_ADDR));
  wire hit_evt = (reg_addr == ADDR_W'(EVT_ADDR));
  wire wr_smi  = reg_we && hit_smi;
  wire wr_evt  = reg_we && hit_evt;
  wire ring    = wr_evt && (|reg_be) && irq_enable && !irq_mask;

  for (genvar l = 0; l < 2; l++) begin : g_smi
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                 smi_q[l*8 +: 8] <= '0;
      else if (wr_smi && reg_be[l]) smi_q[l*8 +: 8] <= reg_wdata[l*8 +: 8];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                 evt_q[l*8 +: 8] <= '0;
      else if (wr_evt && reg_be[l]) evt_q[l*8 +: 8] <= reg_wdata[l*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= ring;

  assign smi_out   = smi_q[0];
  assign irq_pulse = irq_q;
  assign reg_rdata = hit_smi ? {16'h0, smi_q} : hit_evt ? evt_q : 32'h0;

  a_r3_smi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_smi && reg_be[0]) |=> $stable(smi_out));
  a_r4_evt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_evt |=> $stable(evt_q));
  a_r5_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(reg_we));
  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_mask) |-> !irq_pulse);
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(irq_enable) |-> !irq_pulse);
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_smi && !hit_evt) |-> (reg_rdata == 32'h0));
  a_r9_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> (!irq_pulse && $stable(smi_q) && $stable(evt_q)));
endmodule

// File: tb/sim_doorbell_regs.sv
module sim_doorbell_regs;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  reg_addr = 0;
  logic [3:0]  reg_be = 0;
  logic [31:0] reg_wdata = 0;
  logic        reg_we = 0, irq_enable = 0, irq_mask = 0;
  logic [31:0] reg_rdata;
  logic        smi_out, irq_pulse;
  int compared = 0, mismatched = 0;

  logic [15:0] m_smi;
  logic [7:0]  m_evt [4];
  logic        m_irq;

  always #2.5 clk = ~clk;

  doorbell_regs u0 (.clk, .rst_n, .reg_addr, .reg_be, .reg_wdata, .reg_we,
                    .reg_rdata, .irq_enable, .irq_mask, .smi_out, .irq_pulse);

  function automatic logic [31:0] m_read(input logic [7:0] a);
    if (a == 8'hE0) return {16'h0, m_smi};
    if (a == 8'hE4) return {m_evt[3], m_evt[2], m_evt[1], m_evt[0]};
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk({req, " rdata"}, reg_rdata, m_read(reg_addr));
    chk({req, " smi"}, {31'h0, smi_out}, {31'h0, m_smi[0]});
    chk({req, " irq"}, {31'h0, irq_pulse}, {31'h0, m_irq});
  endtask

  task automatic step(input string req, input logic we, input logic [7:0] a,
                      input logic [3:0] be, input logic [31:0] d,
                      input logic en, input logic mk);
    reg_we = we; reg_addr = a; reg_be = be; reg_wdata = d;
    irq_enable = en; irq_mask = mk;
    @(posedge clk);
    m_irq = we && a == 8'hE4 && |be && en && !mk;
    if (we && a == 8'hE0)
      for (int i = 0; i < 2; i++) if (be[i]) m_smi[i*8 +: 8] = d[i*8 +: 8];
    if (we && a == 8'hE4)
      for (int i = 0; i < 4; i++) if (be[i]) m_evt[i] = d[i*8 +: 8];
    @(negedge clk);
    reg_we = 0;
    compare_all(req);
  endtask

  initial begin
    #100000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    m_smi = 0; m_irq = 0;
    for (int i = 0; i < 4; i++) m_evt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    reg_addr = 8'hE0; #1 compare_all("R1 reset E0");
    reg_addr = 8'hE4; #1 compare_all("R1 reset E4");
    // R2/R3 SMI register
    step("R2 full write", 1, 8'hE0, 4'hF, 32'hFFFF_A5C3, 0, 0);
    step("R3 upper only", 1, 8'hE0, 4'h2, 32'h0000_1200, 0, 0);
    step("R3 clear bit0", 1, 8'hE0, 4'h1, 32'h0000_0040, 0, 0);
    step("R3 set bit0", 1, 8'hE0, 4'h1, 32'h0000_0007, 0, 0);
    step("R3 hold", 0, 8'hE0, 4'hF, 32'h0, 0, 0);
    // R4/R5/R6 doorbell
    step("R5 byte ring", 1, 8'hE4, 4'h4, 32'h0011_2233, 1, 0);
    step("R5 pulse ends", 0, 8'hE4, 4'h0, 32'h0, 1, 0);
    step("R6 word ring", 1, 8'hE4, 4'h3, 32'hAAAA_BEEF, 1, 0);
    step("R6 dword ring", 1, 8'hE4, 4'hF, 32'h1234_5678, 1, 0);
    step("R6 after", 0, 8'hE4, 4'h0, 32'h0, 1, 0);
    step("R4 lane3", 1, 8'hE4, 4'h8, 32'h9900_0000, 1, 0);
    // R7 suppression
    step("R7 masked", 1, 8'hE4, 4'h1, 32'h0000_0055, 1, 1);
    step("R7 disabled", 1, 8'hE4, 4'h2, 32'h0000_6600, 0, 0);
    step("R7 no be", 1, 8'hE4, 4'h0, 32'hFFFF_FFFF, 1, 0);
    step("R7 idle", 0, 8'hE4, 4'h0, 32'h0, 1, 0);
    // R8 unmapped
    step("R8 write E8", 1, 8'hE8, 4'hF, 32'hDEAD_BEEF, 1, 0);
    step("R8 write E2", 1, 8'hE2, 4'hF, 32'hFFFF_FFFF, 1, 0);
    step("R8 write 00", 1, 8'h00, 4'hF, 32'hFFFF_FFFF, 1, 0);
    step("R8 check E0", 0, 8'hE0, 4'h0, 32'h0, 1, 0);
    step("R8 check E4", 0, 8'hE4, 4'h0, 32'h0, 1, 0);
    // R9 reads
    for (int k = 0; k < 4; k++)
      step("R9 read", 0, (k % 2) ? 8'hE4 : 8'hE0, 4'hF, 32'hFFFF_FFFF, 1, 0);
    step("R3 clear via word", 1, 8'hE0, 4'h3, 32'h0, 1, 0);
    step("R3 clear hold", 0, 8'hE0, 4'h0, 32'h0, 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule